// File: doc/BRIEF.md
# Two-Port Packet Switch with Selectable Forwarding Discipline

This block is a 2x2 switch for flit-framed packets. Each of its two input ports has a buffer filled through a valid/ready handshake. Each of its two output ports is a valid/ready source that honours backpressure from downstream.

The first flit of a packet selects the output port. That output then belongs to the packet until its last flit has left. A static two-bit selector chooses one of three forwarding disciplines on the same datapath:

- **Whole-packet buffering:** a packet waits in its input buffer until the entire packet has arrived.
- **Cut-through with full absorption:** forwarding starts right after the header, and a stalled packet can be absorbed completely into the input buffer.
- **Worm-style streaming:** forwarding also starts right after the header, but each input holds only two flits, so a stall pushes back on the upstream sender almost at once.

The selector is meant to be set while reset is held and left alone afterwards. When both inputs want the same free output, a two-way round-robin picks between them. Packets bound for different outputs move at the same time.

Top module: `pkt_switch2x2`

## Requirements
- R1: After a synchronous active-high reset, both in_ready bits are 1, both out_valid bits are 0 and every buffer is empty, whatever traffic came before.
- R2: A flit is {type[1:0], payload[DW-1:0]}. Type 00 is a header, 01 a body flit, 10 a tail, 11 a single-flit packet. Only a header's (00 or 11) payload bit 0 selects the output. Every later flit of that packet leaves the same output in arrival order, whatever its own bit 0.
- R3: With mode = 0 (whole-packet buffering), no flit of a packet is offered at an output before its last flit has been accepted. With a free output, out_valid rises two cycles after the cycle in which the last flit was accepted.
- R4: With mode = 1 or mode = 2 (either cut-through discipline), and with an empty buffer and a free output, out_valid rises two cycles after the cycle in which the header was accepted, even though the rest of the packet has not arrived.
- R5: With mode = 1 and a blocked output, an input accepts exactly 16 flits (DEPTH) and then drops in_ready. Once the output unblocks, the buffered flits stream out without waiting for the packet's tail.
- R6: With mode = 2 and a blocked output, an input accepts exactly 2 flits (WORM_DEPTH) and then drops in_ready.
- R7: While out_valid is 1 and out_ready is 0, the output keeps out_valid at 1 and out_flit unchanged.
- R8: Once an output is granted to an input, no flit from the other input appears on it until the granted packet's tail (type 10 or 11) has been sent.
- R9: When both inputs request the same free output in the same cycle, input 0 wins the first such contest after reset. After any grant, the input that was not granted is preferred.
- R10: Packets headed to different outputs are granted and forwarded concurrently.
- R11: An output is released in the cycle after its tail flit is accepted downstream, and can be granted again from the following cycle.
- R12: Packets of up to 16 flits are carried intact in mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Discipline: 0 whole-packet, 1 cut-through with absorption, 2 worm-style |
| in_valid | input | 2 | Per-input flit valid |
| in_flit | input | 2 x (DW+2) | Per-input flit: type in the top two bits, payload below |
| in_ready | output | 2 | Per-input buffer can accept a flit |
| out_valid | output | 2 | Per-output flit valid |
| out_flit | output | 2 x (DW+2) | Per-output flit |
| out_ready | input | 2 | Per-output downstream can accept |

## Verification
Two things can fall in the same cycle:

1. **Output release and a contested re-arbitration.** One input's tail leaves an output while that input's next header and the other input's header are both already waiting for it. The bench provokes this by blocking the output while input 0 queues two packets and input 1 queues one packet, all to output 0, and then unblocking it. It judges the outcome from the order of flits at the output: first packet, then the other input's packet, then the second packet.
2. **Concurrent grants to both outputs.** The bench starts two packets toward different outputs in the same cycle. It requires both out_valid bits to rise in the same cycle, two cycles later.

// File: rtl/pkt_switch_pkg.sv
package pkt_switch_pkg;

  typedef enum logic [1:0] {
    MODE_WHOLE = 2'd0,
    MODE_CUT   = 2'd1,
    MODE_WORM  = 2'd2
  } sw_mode_e;

  localparam logic [1:0] FT_HEAD = 2'b00;
  localparam logic [1:0] FT_BODY = 2'b01;
  localparam logic [1:0] FT_TAIL = 2'b10;
  localparam logic [1:0] FT_SOLO = 2'b11;

  function automatic logic ft_opens(input logic [1:0] t);
    return (t == FT_HEAD) || (t == FT_SOLO);
  endfunction

  function automatic logic ft_closes(input logic [1:0] t);
    return (t == FT_TAIL) || (t == FT_SOLO);
  endfunction

endpackage

// File: rtl/ps_in_buf.sv
module ps_in_buf
  import pkt_switch_pkg::*;
#(
  parameter int FW         = 10,
  parameter int DEPTH      = 16,
  parameter int WORM_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          small_cap,
  input  logic          whole_mode,
  input  logic          wr_valid,
  input  logic [FW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_pop,
  output logic          rd_valid,
  output logic [FW-1:0] rd_data,
  output logic          pkt_whole
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [FW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, tails, cap;
  logic          push, tail_in, tail_out;

  assign cap      = small_cap ? CW'(WORM_DEPTH) : CW'(DEPTH);
  assign wr_ready = count < cap;
  assign push     = wr_valid && wr_ready;
  assign rd_valid = count != '0;
  assign rd_data  = mem[rd_ptr];
  assign pkt_whole = tails != '0;
  assign tail_in  = push && ft_closes(wr_data[FW-1 -: 2]);
  assign tail_out = rd_pop && ft_closes(rd_data[FW-1 -: 2]);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      tails  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (rd_pop) rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      case ({push, rd_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({tail_in, tail_out})
        2'b10:   tails <= tails + 1'b1;
        2'b01:   tails <= tails - 1'b1;
        default: tails <= tails;
      endcase
    end
  end

  // R2: the switch never pops an empty buffer
  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> (count != '0));

  // R3: in whole-packet mode a header leaves only once a complete packet is held
  a_r3_whole_before_send: assert property (@(posedge clk) disable iff (rst)
    (whole_mode && rd_pop && ft_opens(rd_data[FW-1 -: 2])) |-> (tails != '0));

  // R6: occupancy never exceeds the mode's capacity
  a_r6_within_cap: assert property (@(posedge clk) disable iff (rst)
    count <= cap);

endmodule

// File: rtl/ps_out_alloc.sv
module ps_out_alloc (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic       last_fire,
  output logic       busy,
  output logic       owner
);

  logic prio;
  logic winner;

  assign winner = (req[0] && req[1]) ? prio : req[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      owner <= 1'b0;
      prio  <= 1'b0;
    end else if (busy) begin
      if (last_fire) busy <= 1'b0;
    end else if (|req) begin
      busy  <= 1'b1;
      owner <= winner;
      prio  <= ~winner;
    end
  end

  // R8: the grant and its owner stay put until the tail has gone
  a_r8_hold_until_tail: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_fire) |=> (busy && $stable(owner)));

  // R9: a new grant always goes to an input that was requesting
  a_r9_grant_requester: assert property (@(posedge clk) disable iff (rst)
    (!busy && (|req)) |=> (busy && (owner ? $past(req[1]) : $past(req[0]))));

  // R11: the output frees up in the cycle after its tail is accepted
  a_r11_release_after_tail: assert property (@(posedge clk) disable iff (rst)
    (busy && last_fire) |=> !busy);

endmodule

// File: rtl/pkt_switch2x2.sv
module pkt_switch2x2
  import pkt_switch_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH      = 16,
  parameter int WORM_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic [1:0]           in_valid,
  input  logic [1:0][DW+1:0]   in_flit,
  output logic [1:0]           in_ready,
  output logic [1:0]           out_valid,
  output logic [1:0][DW+1:0]   out_flit,
  input  logic [1:0]           out_ready
);

  localparam int FW    = DW + 2;
  localparam int PORTS = 2;

  sw_mode_e mode_e;
  logic     whole_mode, small_cap;

  assign mode_e     = sw_mode_e'(mode);
  assign whole_mode = (mode_e == MODE_WHOLE);
  assign small_cap  = !(mode_e == MODE_WHOLE || mode_e == MODE_CUT);

  logic [PORTS-1:0][FW-1:0] hd;
  logic [PORTS-1:0]         hv, whole, pop, in_busy, elig;
  logic [PORTS-1:0]         busy, owner, last_fire;
  logic [PORTS-1:0][1:0]    req_m;

  // input side: one buffer per port
  for (genvar gi = 0; gi < PORTS; gi++) begin : g_in
    ps_in_buf #(
      .FW(FW), .DEPTH(DEPTH), .WORM_DEPTH(WORM_DEPTH)
    ) u_buf (
      .clk       (clk),
      .rst       (rst),
      .small_cap (small_cap),
      .whole_mode(whole_mode),
      .wr_valid  (in_valid[gi]),
      .wr_data   (in_flit[gi]),
      .wr_ready  (in_ready[gi]),
      .rd_pop    (pop[gi]),
      .rd_valid  (hv[gi]),
      .rd_data   (hd[gi]),
      .pkt_whole (whole[gi])
    );
  end

  // ownership and requests
  always_comb begin
    for (int i = 0; i < PORTS; i++) begin
      in_busy[i] = 1'b0;
      pop[i]     = 1'b0;
      for (int o = 0; o < PORTS; o++) begin
        if (busy[o] && (owner[o] == 1'(i))) begin
          in_busy[i] = 1'b1;
          if (out_ready[o] && hv[i]) pop[i] = 1'b1;
        end
      end
      elig[i] = hv[i] && ft_opens(hd[i][FW-1 -: 2]) && !in_busy[i] &&
                (!whole_mode || whole[i]);
    end
    for (int o = 0; o < PORTS; o++) begin
      for (int i = 0; i < PORTS; i++) begin
        req_m[o][i] = elig[i] && (hd[i][0] == 1'(o));
      end
    end
  end

  // output side: one allocator per port
  for (genvar go = 0; go < PORTS; go++) begin : g_out
    ps_out_alloc u_alloc (
      .clk      (clk),
      .rst      (rst),
      .req      (req_m[go]),
      .last_fire(last_fire[go]),
      .busy     (busy[go]),
      .owner    (owner[go])
    );

    assign out_valid[go] = busy[go] && hv[owner[go]];
    assign out_flit[go]  = hd[owner[go]];
    assign last_fire[go] = out_valid[go] && out_ready[go] &&
                           ft_closes(out_flit[go][FW-1 -: 2]);

    // R7: a stalled output holds its flit
    a_r7_stall_stable: assert property (@(posedge clk) disable iff (rst)
      (out_valid[go] && !out_ready[go]) |=> (out_valid[go] && $stable(out_flit[go])));
  end

endmodule

// File: tb/pkt_switch2x2_tb.sv
`timescale 1ns/1ps
module pkt_switch2x2_tb;

  localparam int DW = 8;
  localparam int FW = DW + 2;
  localparam int MAXF = 64;
  localparam int WATCH_CYC = 20000;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [1:0]            mode = 2'd0;
  logic [1:0]            in_valid = '0;
  logic [1:0][FW-1:0]    in_flit = '0;
  logic [1:0]            in_ready;
  logic [1:0]            out_valid;
  logic [1:0][FW-1:0]    out_flit;
  logic [1:0]            out_ready = '0;

  always #10 clk = ~clk;

  pkt_switch2x2 #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .mode(mode),
    .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [FW-1:0] src_f [2][MAXF];
  int            src_n [2];
  logic [FW-1:0] rcv_f [2][MAXF];
  int            rcv_n [2];
  logic [FW-1:0] exp_f [MAXF];
  int            exp_n;
  int            first_v [2];
  int            last_acc [2];
  int            start_c [2];
  int            rdy_from [2];
  int            idx [2];

  // {mode[1:0], len0[4:0], dst0, len1[4:0], dst1, start1[3:0]}
  localparam logic [17:0] TBL [6] = '{
    {2'd0, 5'd4, 1'b1, 5'd0, 1'b0, 4'd0},
    {2'd1, 5'd5, 1'b0, 5'd0, 1'b0, 4'd0},
    {2'd2, 5'd6, 1'b1, 5'd0, 1'b0, 4'd0},
    {2'd1, 5'd3, 1'b0, 5'd4, 1'b1, 4'd0},
    {2'd2, 5'd1, 1'b0, 5'd3, 1'b1, 4'd1},
    {2'd0, 5'd6, 1'b0, 5'd3, 1'b1, 4'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_scn();
    for (int i = 0; i < 2; i++) begin
      src_n[i] = 0; rcv_n[i] = 0; first_v[i] = -1; last_acc[i] = -1;
      start_c[i] = 0; rdy_from[i] = 0; idx[i] = 0;
    end
  endtask

  task automatic add_pkt(input int s, input int d, input int len);
    for (int k = 0; k < len; k++) begin
      logic [1:0]    t;
      logic [DW-1:0] p;
      if (len == 1)          t = 2'b11;
      else if (k == 0)       t = 2'b00;
      else if (k == len - 1) t = 2'b10;
      else                   t = 2'b01;
      if (k == 0) p = {s[0], 6'(src_n[s]), d[0]};
      else        p = {s[0], 7'(src_n[s] * 3 + 1)};
      src_f[s][src_n[s]] = {t, p};
      src_n[s]++;
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; in_valid = '0; out_ready = '0; mode = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int ncyc);
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        in_valid[i] = (cyc >= start_c[i]) && (idx[i] < src_n[i]);
        in_flit[i]  = (idx[i] < src_n[i]) ? src_f[i][idx[i]] : '0;
      end
      for (int o = 0; o < 2; o++) out_ready[o] = (cyc >= rdy_from[o]);
      #1;
      for (int i = 0; i < 2; i++) begin
        if (in_valid[i] && in_ready[i]) begin
          if (idx[i] == src_n[i] - 1) last_acc[i] = cyc;
          idx[i]++;
        end
      end
      for (int o = 0; o < 2; o++) begin
        if (out_valid[o] && first_v[o] < 0) first_v[o] = cyc;
        if (out_valid[o] && out_ready[o] && rcv_n[o] < MAXF) begin
          rcv_f[o][rcv_n[o]] = out_flit[o];
          rcv_n[o]++;
        end
      end
    end
    in_valid = '0;
  endtask

  task automatic build_exp(input int o);
    exp_n = 0;
    for (int i = 0; i < 2; i++) begin
      int cur = -1;
      for (int k = 0; k < src_n[i]; k++) begin
        if (src_f[i][k][FW-1 -: 2] == 2'b00 || src_f[i][k][FW-1 -: 2] == 2'b11)
          cur = int'(src_f[i][k][0]);
        if (cur == o) begin exp_f[exp_n] = src_f[i][k]; exp_n++; end
      end
    end
  endtask

  task automatic chk_stream(input int o, input string req);
    int bad = 0;
    if (rcv_n[o] != exp_n) bad = 1;
    else
      for (int k = 0; k < exp_n; k++) if (rcv_f[o][k] !== exp_f[k]) bad = 1;
    chk(bad == 0, req, rcv_n[o], exp_n);
  endtask

  initial begin
    #(WATCH_CYC * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(2'd1);
    #1;
    chk(in_ready == 2'b11 && out_valid == 2'b00, "R1 reset state",
        int'({in_ready, out_valid}), int'(4'b1100));

    // vector table
    for (int e = 0; e < 6; e++) begin
      logic [1:0] m;
      int l0, l1, d0, d1;
      m  = TBL[e][17:16];
      l0 = int'(TBL[e][15:11]); d0 = int'(TBL[e][10]);
      l1 = int'(TBL[e][9:5]);   d1 = int'(TBL[e][4]);
      do_reset(m);
      clear_scn();
      if (l0 > 0) add_pkt(0, d0, l0);
      if (l1 > 0) add_pkt(1, d1, l1);
      start_c[1] = int'(TBL[e][3:0]);
      run(60);
      for (int i = 0; i < 2; i++) begin
        int ln, dd, expv;
        ln = (i == 0) ? l0 : l1;
        dd = (i == 0) ? d0 : d1;
        if (ln > 0) begin
          if (m == 2'd0) begin
            expv = last_acc[i] + 2;
            chk(first_v[dd] == expv, "R3 whole-packet start", first_v[dd], expv);
          end else begin
            expv = start_c[i] + 2;
            chk(first_v[dd] == expv, "R4 cut-through start", first_v[dd], expv);
          end
          build_exp(dd);
          chk_stream(dd, "R2 flit routing and order");
        end
      end
      if (l0 > 0 && l1 > 0 && d0 != d1 && start_c[1] == 0)
        chk(first_v[0] == first_v[1], "R10 concurrent outputs", first_v[0], first_v[1]);
    end

    // R5 absorption with blocked output
    do_reset(2'd1);
    clear_scn();
    add_pkt(0, 0, 20);
    rdy_from[0] = 1000;
    run(30);
    chk(idx[0] == 16, "R5 absorbed flits", idx[0], 16);
    chk(in_ready[0] == 1'b0, "R5 in_ready low when full", int'(in_ready[0]), 0);
    chk(out_valid[0] == 1'b1 && out_flit[0] == src_f[0][0], "R7 stalled output holds header",
        int'(out_flit[0]), int'(src_f[0][0]));

    // R1 reset clears a full buffer
    do_reset(2'd1);
    #1;
    chk(in_ready == 2'b11 && out_valid == 2'b00, "R1 reset after traffic",
        int'({in_ready, out_valid}), int'(4'b1100));

    // R5 resume before tail arrives
    clear_scn();
    add_pkt(0, 1, 12);
    rdy_from[1] = 5;
    start_c[0] = 0;
    run(40);
    chk(first_v[1] == 2, "R5 header offered early", first_v[1], 2);
    build_exp(1);
    chk_stream(1, "R5 resumed stream");

    // R6 worm-style capacity
    do_reset(2'd2);
    clear_scn();
    add_pkt(1, 0, 20);
    rdy_from[0] = 1000;
    run(20);
    chk(idx[1] == 2, "R6 worm capacity", idx[1], 2);
    chk(in_ready[1] == 1'b0, "R6 in_ready low", int'(in_ready[1]), 0);

    // R12 longest packet in whole-packet mode
    do_reset(2'd0);
    clear_scn();
    add_pkt(0, 1, 16);
    run(50);
    chk(first_v[1] == last_acc[0] + 2, "R12 16-flit start", first_v[1], last_acc[0] + 2);
    build_exp(1);
    chk_stream(1, "R12 16-flit intact");

    // R8 R9 R11: contested output, release and re-arbitration
    do_reset(2'd1);
    clear_scn();
    add_pkt(0, 0, 3);
    add_pkt(0, 0, 2);
    add_pkt(1, 0, 3);
    rdy_from[0] = 4;
    run(40);
    exp_n = 0;
    for (int k = 0; k < 3; k++) begin exp_f[exp_n] = src_f[0][k]; exp_n++; end
    for (int k = 0; k < 3; k++) begin exp_f[exp_n] = src_f[1][k]; exp_n++; end
    for (int k = 3; k < 5; k++) begin exp_f[exp_n] = src_f[0][k]; exp_n++; end
    chk_stream(0, "R9 R8 R11 arbitration order");
    chk(rcv_n[1] == 0, "R2 nothing on unused output", rcv_n[1], 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule